// File: doc/BRIEF.md
# USB Device Suspend and Reset Supervisor

This block tracks the bus power state of a full-speed USB device function. It measures how long the bus has been idle, using a coarse timebase tick (1 ms or finer) and a line-activity indication from the bus receiver. When the device is attached and the bus stays quiet for a programmed number of ticks, the block enters suspend and drops the USB clock enable. Any later bus activity restores the clock and ends suspend.

A small control register holds the software settings. One bit chooses whether a detected bus reset also resets the processor core, or only the USB logic. Another bit allows remote wakeup. Writing the wakeup request bit while suspended starts a timed drive of the resume request toward the transceiver. The device then stays suspended until the host answers with resume activity.

Top module: `usb_pwr_supervisor`

## Requirements
- R1: After synchronous reset the block is not suspended. The clock enable is 1. Core reset, USB-logic reset and the wake drive are all 0. The control readback is 8'h04.
- R2: While the block is active and attached, and there is no line activity, IDLE_TICKS consecutive ticks put the block in suspend on the clock edge that samples the last tick. The clock enable goes to 0 on the same edge.
- R3: Line activity restarts the idle count from zero. While `attached` is low, the idle count is held at zero.
- R4: In suspend, when not driving a wakeup, line activity returns the block to active on the next edge and sets the clock enable back to 1.
- R5: The coupling bit is control bit 7. If it was 1 before the edge that samples `bus_reset`, then `core_rst` is high for exactly RST_CYCLES cycles, starting on that edge. A new bus reset during the pulse restarts it.
- R6: Every bus reset gives a one-cycle `usb_logic_rst` on the edge that samples it. When the coupling bit is 0, a bus reset leaves `core_rst` unchanged.
- R7: A bus reset ends suspend or wakeup at once, sets the clock enable to 1 and restarts the idle count.
- R8: The wake-enable bit is control bit 0 and the wake request is control bit 1. Writing bit 1 as 1 while suspended, with the stored wake-enable at 1, raises `remote_wake_drive` on the next edge for RWK_TICKS ticks. The drive then falls, and the block stays suspended until line activity arrives.
- R9: A wake request written while active, while wake-enable is 0, or while already waking is ignored: `remote_wake_drive` stays 0 and the state does not change.
- R10: Line activity seen while the wake drive is on is ignored. The drive continues and the block stays suspended.
- R11: The readback layout is: bit 7 is coupling, bit 2 is clock enable, bit 1 is wake drive active, bit 0 is wake enable, and bits 6..3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| attached | input | 1 | Device is connected to the bus |
| line_active | input | 1 | Bus receiver sees non-idle line state |
| bus_reset | input | 1 | Bus reset detected this cycle |
| tick | input | 1 | One-cycle timebase strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control/status readback |
| usb_clk_en | output | 1 | USB clock enable |
| usb_logic_rst | output | 1 | One-cycle reset for USB logic |
| core_rst | output | 1 | Processor core reset pulse |
| suspended | output | 1 | Device is in suspend (including wakeup) |
| remote_wake_drive | output | 1 | Request transceiver to signal resume |

## Verification
The bench builds the block with IDLE_TICKS=3, RWK_TICKS=2 and RST_CYCLES=4, and pulses the tick once every four clocks. With these small values, suspend entry, the end of the wake drive, and a core reset pulse re-triggered near its end can each be reached in a few dozen cycles. The run can therefore cover the full chain: active, then suspend, then wake drive, then waiting, then active again, several times with different enable and coupling settings. A behavioural model compares every output on every clock.

// File: rtl/usbps_pkg.sv
package usbps_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE     = 2'd0,
        PS_SUSPEND    = 2'd1,
        PS_WAKE_DRIVE = 2'd2,
        PS_WAKE_WAIT  = 2'd3
    } pwr_state_e;

    localparam int CTL_W          = 8;
    localparam int BIT_COUPLE     = 7;
    localparam int BIT_CLKEN      = 2;
    localparam int BIT_WAKE_REQ   = 1;
    localparam int BIT_WAKE_EN    = 0;

    typedef struct packed {
        logic couple;
        logic wake_en;
    } ctl_cfg_t;

    function automatic logic in_suspend(pwr_state_e s);
        return s != PS_ACTIVE;
    endfunction

    function automatic logic [CTL_W-1:0] pack_status(ctl_cfg_t c, logic clk_en, logic waking);
        logic [CTL_W-1:0] v;
        v = '0;
        v[BIT_COUPLE]   = c.couple;
        v[BIT_CLKEN]    = clk_en;
        v[BIT_WAKE_REQ] = waking;
        v[BIT_WAKE_EN]  = c.wake_en;
        return v;
    endfunction

endpackage

// File: rtl/usbps_tick_counter.sv
module usbps_tick_counter #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = en && !clr && tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || done)
            cnt <= '0;
        else if (en && tick)
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/usbps_reset_pulser.sv
module usbps_reset_pulser #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (trigger)
            left <= CW'(LEN);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign pulse = (left != '0);

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        trigger |=> pulse);

    // R6
    pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !trigger && !pulse |=> !pulse);

endmodule

// File: rtl/usb_pwr_supervisor.sv
module usb_pwr_supervisor
    import usbps_pkg::*;
#(
    parameter int IDLE_TICKS = 3,
    parameter int RWK_TICKS  = 10,
    parameter int RST_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             attached,
    input  logic             line_active,
    input  logic             bus_reset,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             usb_clk_en,
    output logic             usb_logic_rst,
    output logic             core_rst,
    output logic             suspended,
    output logic             remote_wake_drive
);
    pwr_state_e state, state_nx;
    ctl_cfg_t   cfg;
    logic       clk_en_q, clk_en_nx;
    logic       ulr_q;
    logic       idle_done, wake_done;
    logic       idle_clr, wake_clr;
    logic       wake_req;
    logic       ctl_unused;

    assign ctl_unused = ^ctl_wdata[6:2];

    assign wake_req = ctl_wr && ctl_wdata[BIT_WAKE_REQ] && cfg.wake_en;

    assign idle_clr = bus_reset || !attached || line_active || (state != PS_ACTIVE);
    assign wake_clr = bus_reset || (state != PS_WAKE_DRIVE);

    usbps_tick_counter #(.LIMIT(IDLE_TICKS)) idle_ctr_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (idle_clr),
        .en   (state == PS_ACTIVE),
        .tick (tick),
        .done (idle_done)
    );

    usbps_tick_counter #(.LIMIT(RWK_TICKS)) wake_ctr_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (wake_clr),
        .en   (1'b1),
        .tick (tick),
        .done (wake_done)
    );

    usbps_reset_pulser #(.LEN(RST_CYCLES)) core_rst_i (
        .clk     (clk),
        .rst     (rst),
        .trigger (bus_reset && cfg.couple),
        .pulse   (core_rst)
    );

    always_comb begin
        state_nx  = state;
        clk_en_nx = clk_en_q;
        if (bus_reset) begin
            state_nx  = PS_ACTIVE;
            clk_en_nx = 1'b1;
        end else begin
            unique case (state)
                PS_ACTIVE: begin
                    if (idle_done) begin
                        state_nx  = PS_SUSPEND;
                        clk_en_nx = 1'b0;
                    end
                end
                PS_SUSPEND: begin
                    if (line_active) begin
                        state_nx  = PS_ACTIVE;
                        clk_en_nx = 1'b1;
                    end else if (wake_req) begin
                        state_nx = PS_WAKE_DRIVE;
                    end
                end
                PS_WAKE_DRIVE: begin
                    if (wake_done)
                        state_nx = PS_WAKE_WAIT;
                end
                PS_WAKE_WAIT: begin
                    if (line_active) begin
                        state_nx  = PS_ACTIVE;
                        clk_en_nx = 1'b1;
                    end
                end
                default: state_nx = PS_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_ACTIVE;
            clk_en_q <= 1'b1;
            cfg      <= '0;
            ulr_q    <= 1'b0;
        end else begin
            state    <= state_nx;
            clk_en_q <= clk_en_nx;
            ulr_q    <= bus_reset;
            if (ctl_wr) begin
                cfg.couple  <= ctl_wdata[BIT_COUPLE];
                cfg.wake_en <= ctl_wdata[BIT_WAKE_EN];
            end
        end
    end

    assign usb_clk_en        = clk_en_q;
    assign usb_logic_rst     = ulr_q;
    assign suspended         = in_suspend(state);
    assign remote_wake_drive = (state == PS_WAKE_DRIVE);
    assign ctl_rdata         = pack_status(cfg, clk_en_q, remote_wake_drive);

    // R2
    clk_off_in_susp_chk: assert property (@(posedge clk) disable iff (rst)
        suspended |-> !usb_clk_en);

    // R4
    susp_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SUSPEND) && line_active && !bus_reset |=> !suspended && usb_clk_en);

    // R5
    couple_rst_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset && cfg.couple |=> core_rst);

    // R7
    busrst_wake_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !suspended && usb_clk_en && usb_logic_rst);

    // R9
    wake_only_susp_chk: assert property (@(posedge clk) disable iff (rst)
        remote_wake_drive |-> suspended);

    // R10
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        remote_wake_drive && !bus_reset && !wake_done |=> remote_wake_drive);

endmodule

// File: tb/usb_pwr_supervisor_tb.sv
module usb_pwr_supervisor_tb_top;
    localparam int IDLE_T = 3;
    localparam int RWK_T  = 2;
    localparam int RST_C  = 4;
    localparam int TDIV   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       attached = 1'b0, line_active = 1'b0, bus_reset = 1'b0, tick = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       usb_clk_en, usb_logic_rst, core_rst, suspended, remote_wake_drive;

    int checks = 0, fails = 0, cycles = 0, tcount = 0;
    bit done_flag = 0;

    // behavioural model state
    int m_susp = 0, m_idle = 0, m_drive = 0, m_wait = 0, m_rst = 0;
    int m_clk = 1, m_ulr = 0, m_cpl = 0, m_wen = 0;

    always #4 clk = ~clk;

    usb_pwr_supervisor #(.IDLE_TICKS(IDLE_T), .RWK_TICKS(RWK_T), .RST_CYCLES(RST_C)) dut_i (
        .clk(clk), .rst(rst), .attached(attached), .line_active(line_active),
        .bus_reset(bus_reset), .tick(tick), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .usb_clk_en(usb_clk_en), .usb_logic_rst(usb_logic_rst),
        .core_rst(core_rst), .suspended(suspended), .remote_wake_drive(remote_wake_drive)
    );

    always @(posedge clk) begin
        int old_cpl, old_wen;
        cycles++;
        if (rst) begin
            m_susp = 0; m_idle = 0; m_drive = 0; m_wait = 0; m_rst = 0;
            m_clk = 1; m_ulr = 0; m_cpl = 0; m_wen = 0;
        end else begin
            old_cpl = m_cpl; old_wen = m_wen;
            m_ulr = bus_reset;
            if (ctl_wr) begin m_cpl = ctl_wdata[7]; m_wen = ctl_wdata[0]; end
            if (m_rst > 0) m_rst--;
            if (bus_reset) begin
                if (old_cpl != 0) m_rst = RST_C;
                m_susp = 0; m_drive = 0; m_wait = 0; m_idle = 0; m_clk = 1;
            end else if (m_susp == 0) begin
                if (!attached || line_active) m_idle = 0;
                else if (tick) begin
                    m_idle++;
                    if (m_idle == IDLE_T) begin m_susp = 1; m_idle = 0; m_clk = 0; end
                end
            end else if (m_drive > 0) begin
                if (tick) m_drive--;
            end else if (line_active) begin
                m_susp = 0; m_wait = 0; m_clk = 1;
            end else if (m_wait == 0 && ctl_wr && ctl_wdata[1] && old_wen != 0) begin
                m_drive = RWK_T; m_wait = 1;
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            check({7'd0, suspended},         {7'd0, 1'(m_susp != 0)},  "R2 suspended");
            check({7'd0, usb_clk_en},        {7'd0, 1'(m_clk != 0)},   "R4 usb_clk_en");
            check({7'd0, core_rst},          {7'd0, 1'(m_rst > 0)},    "R5 core_rst");
            check({7'd0, usb_logic_rst},     {7'd0, 1'(m_ulr != 0)},   "R6 usb_logic_rst");
            check({7'd0, remote_wake_drive}, {7'd0, 1'(m_drive > 0)},  "R8 remote_wake_drive");
            check(ctl_rdata, {1'(m_cpl != 0), 4'd0, 1'(m_clk != 0), 1'(m_drive > 0), 1'(m_wen != 0)},
                  "R11 ctl_rdata");
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (tcount % TDIV == 0);
            tcount++;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        cyc();
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_act();
        line_active = 1'b1; cyc(); line_active = 1'b0;
    endtask

    task automatic bus_rst();
        bus_reset = 1'b1; cyc(); bus_reset = 1'b0;
    endtask

    task automatic finish_up();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles == 100000 && !done_flag) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc();
        // R1 reset state
        check(ctl_rdata, 8'h04, "R1 readback");
        check({4'd0, suspended, core_rst, usb_logic_rst, remote_wake_drive}, 8'h00, "R1 flags");
        wr(8'h01);
        attached = 1'b1;
        cyc(20);
        check({7'd0, suspended}, 8'h01, "R2 idle entry");
        pulse_act();
        check({7'd0, usb_clk_en}, 8'h01, "R4 activity exit");
        // R3 activity keeps restarting the count
        for (int k = 0; k < 10; k++) begin cyc(6); pulse_act(); end
        check({7'd0, suspended}, 8'h00, "R3 activity keeps awake");
        attached = 1'b0;
        cyc(60);
        check({7'd0, suspended}, 8'h00, "R3 detached holds count");
        attached = 1'b1;
        cyc(20);
        // R8 remote wake
        wr(8'h03);
        check({7'd0, remote_wake_drive}, 8'h01, "R8 drive start");
        pulse_act();
        check({7'd0, remote_wake_drive}, 8'h01, "R10 activity ignored in drive");
        cyc(12);
        check({6'd0, suspended, remote_wake_drive}, 8'h02, "R8 waiting for host");
        wr(8'h03);
        check({7'd0, remote_wake_drive}, 8'h00, "R9 no re-request while waiting");
        pulse_act();
        check({7'd0, suspended}, 8'h00, "R8 host resume ends suspend");
        // R9 ignored cases
        wr(8'h03);
        check({7'd0, remote_wake_drive}, 8'h00, "R9 ignored when active");
        wr(8'h00);
        cyc(20);
        wr(8'h02);
        check({7'd0, remote_wake_drive}, 8'h00, "R9 ignored when disabled");
        cyc(3);
        // R6/R7 bus reset without coupling in suspend
        bus_rst();
        check({6'd0, suspended, core_rst}, 8'h00, "R7 R6 uncoupled reset");
        cyc(20);
        wr(8'h81);
        wr(8'h83);
        cyc(3);
        bus_rst();
        check({7'd0, core_rst}, 8'h01, "R5 coupled reset");
        cyc(2);
        bus_rst();
        cyc(3);
        check({7'd0, core_rst}, 8'h01, "R5 retrigger extends");
        cyc(10);
        check({7'd0, core_rst}, 8'h00, "R5 pulse ended");
        cyc(4);
        finish_up();
    end
endmodule